// File: doc/BRIEF.md
# Memory-Stage IO Address Router

This block is the memory-access stage of a five-stage 32-bit integer pipeline, merged with a small IO decoder. Each cycle it takes the execute stage's effective address (also the ALU result), store data, store enable, load indication, instruction word, program counter and writeback controls. It steers the access either to an external data memory or to a tiny IO space. It also registers everything the writeback stage needs, including a source select that picks IO data, memory data or the ALU result.

IO space holds two registers. One is a read-only push-button register. The other is a write-only 10-bit LED register. Address bit 31 separates IO from RAM. In the same cycle, the block publishes a forwarding triple (enable, destination register, value) that the decode stage uses to resolve data hazards. Hazards through memory are left to software.

Top module: `mem_stage_router`

## Requirements
- R1: An access whose address bit 31 is 1 targets IO space, and an access whose bit 31 is 0 targets RAM. `mem_we` is 1 exactly when `ex_store_en` is 1 and bit 31 is 0. A store to IO space never raises `mem_we`.
- R2: `mem_addr` is always the word address, meaning address bits [31:2], presented in the same cycle.
- R3: The size of a RAM store comes from `ex_iw[13:12]`. The value 00 means byte: `mem_be` = 0001 shifted left by address[1:0]. The value 01 means halfword: `mem_be` = 0011 shifted left by 2*address[1]. Any other value means word: `mem_be` = 1111. The store data is shifted left by 8 bits per lane of that shift, so each byte sits in the lane it enables and unused lanes are zero. `mem_be` is 0000 when there is no RAM store.
- R4: On the clock edge after an access, `wb_src_sel` becomes 10 for an IO load, 01 for a RAM load and 00 for any other access.
- R5: A load from IO word address 0x8000_0000 returns the push-button input in bit 0, with all other bits zero. This value appears on `fwd_data` in the same cycle and on `wb_io_data` after the next edge.
- R6: A store to IO word address 0x8000_0004 loads `ex_store_data[9:0]` into `led_out` at the next edge.
- R7: The button address ignores stores, so `led_out` is unchanged. The LED address reads as zero.
- R8: Loads from any other IO word address return zero, and stores to any other IO word address leave `led_out` unchanged.
- R9: `fwd_reg` equals `ex_wb_reg`. `fwd_en` equals `ex_wb_en`, except that it is 0 during a RAM load. `fwd_data` is the IO read value during an IO load and the ALU result otherwise. All three are combinational.
- R10: A synchronous active-high reset clears `wb_en`, `wb_reg`, `wb_pc`, `wb_iw`, `wb_alu`, `wb_src_sel`, `wb_io_data` and `led_out` to zero.
- R11: `wb_en`, `wb_reg`, `wb_pc`, `wb_iw` and `wb_alu` carry the execute-stage values one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ex_wb_en | input | 1 | Instruction writes a register |
| ex_wb_reg | input | 5 | Destination register index |
| ex_pc | input | 32 | Program counter of the instruction |
| ex_iw | input | 32 | Instruction word (bits 13:12 give store size) |
| ex_alu | input | 32 | ALU result / effective address |
| ex_store_data | input | 32 | Unaligned store data |
| ex_store_en | input | 1 | Instruction is a store |
| ex_is_load | input | 1 | Instruction is a load |
| mem_we | output | 1 | RAM write enable |
| mem_be | output | 4 | RAM byte-lane enables |
| mem_addr | output | 30 | RAM word address |
| mem_wdata | output | 32 | Lane-aligned RAM write data |
| btn_in | input | 1 | Push-button level |
| led_out | output | 10 | LED register |
| fwd_en | output | 1 | Forwarding valid to decode |
| fwd_reg | output | 5 | Forwarded register index |
| fwd_data | output | 32 | Forwarded value |
| wb_en | output | 1 | Registered writeback enable |
| wb_reg | output | 5 | Registered destination index |
| wb_pc | output | 32 | Registered program counter |
| wb_iw | output | 32 | Registered instruction word |
| wb_alu | output | 32 | Registered ALU result |
| wb_src_sel | output | 2 | Registered writeback source select |
| wb_io_data | output | 32 | Registered IO read value |

## Verification
The memory-side outputs and the forwarding triple are combinational. The bench drives each access just after a falling edge and compares these outputs one time unit later, in the same cycle. The writeback registers and `led_out` take one rising edge. They are compared at the following falling edge against values the bench computed from the stimulus it held during that edge. The bench keeps its own LED model so that ignored stores show up as an unchanged `led_out` in that same sample.

// File: rtl/mem_router_pkg.sv
package mem_router_pkg;

    localparam int XLEN   = 32;
    localparam int RIDX_W = 5;

    typedef enum logic [1:0] {
        SRC_ALU = 2'b00,
        SRC_MEM = 2'b01,
        SRC_IO  = 2'b10
    } wb_src_e;

    typedef struct packed {
        logic              en;
        logic [RIDX_W-1:0] rd;
        logic [XLEN-1:0]   pc;
        logic [XLEN-1:0]   iw;
        logic [XLEN-1:0]   alu;
        wb_src_e           src;
        logic [XLEN-1:0]   io_data;
    } wb_pipe_t;

endpackage

// File: rtl/store_lane_align.sv
module store_lane_align #(
    parameter int DW = 32
) (
    input  logic [1:0]      size_code,
    input  logic [1:0]      byte_off,
    input  logic [DW-1:0]   data_in,
    output logic [DW/8-1:0] lane_en,
    output logic [DW-1:0]   data_out
);
    localparam int NB = DW / 8;

    logic [NB-1:0] be_c;
    logic [DW-1:0] wd_c;
    logic [DW-1:0] byte_z;
    logic [DW-1:0] half_z;

    assign byte_z = {{(DW-8){1'b0}},  data_in[7:0]};
    assign half_z = {{(DW-16){1'b0}}, data_in[15:0]};

    always_comb begin
        case (size_code)
            2'b00: begin
                be_c = {{(NB-1){1'b0}}, 1'b1} << byte_off;
                wd_c = byte_z << (8 * byte_off);
            end
            2'b01: begin
                be_c = {{(NB-2){1'b0}}, 2'b11} << (2 * byte_off[1]);
                wd_c = half_z << (16 * byte_off[1]);
            end
            default: begin
                be_c = '1;
                wd_c = data_in;
            end
        endcase
    end

    assign lane_en  = be_c;
    assign data_out = wd_c;
endmodule

// File: rtl/io_space.sv
module io_space #(
    parameter int DW    = 32,
    parameter int AW    = 29,
    parameter int LED_W = 10,
    parameter int BTN_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    word_idx,
    input  logic             rd,
    input  logic             wr,
    input  logic [LED_W-1:0] wdata,
    input  logic [BTN_W-1:0] btn,
    output logic [DW-1:0]    rdata,
    output logic [LED_W-1:0] led
);
    localparam logic [AW-1:0] BTN_IDX = AW'(0);
    localparam logic [AW-1:0] LED_IDX = AW'(1);

    logic [LED_W-1:0] led_d, led_q;

    always_comb begin
        led_d = led_q;
        if (wr && word_idx == LED_IDX) begin
            led_d = wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd && word_idx == BTN_IDX) begin
            rdata = {{(DW-BTN_W){1'b0}}, btn};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) led_q <= '0;
        else     led_q <= led_d;
    end

    assign led = led_q;
endmodule

// File: rtl/mem_stage_router.sv
module mem_stage_router
    import mem_router_pkg::*;
#(
    parameter int LED_W = 10,
    parameter int BTN_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ex_wb_en,
    input  logic [RIDX_W-1:0] ex_wb_reg,
    input  logic [XLEN-1:0]   ex_pc,
    input  logic [XLEN-1:0]   ex_iw,
    input  logic [XLEN-1:0]   ex_alu,
    input  logic [XLEN-1:0]   ex_store_data,
    input  logic              ex_store_en,
    input  logic              ex_is_load,
    output logic              mem_we,
    output logic [XLEN/8-1:0] mem_be,
    output logic [XLEN-3:0]   mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic [BTN_W-1:0]  btn_in,
    output logic [LED_W-1:0]  led_out,
    output logic              fwd_en,
    output logic [RIDX_W-1:0] fwd_reg,
    output logic [XLEN-1:0]   fwd_data,
    output logic              wb_en,
    output logic [RIDX_W-1:0] wb_reg,
    output logic [XLEN-1:0]   wb_pc,
    output logic [XLEN-1:0]   wb_iw,
    output logic [XLEN-1:0]   wb_alu,
    output logic [1:0]        wb_src_sel,
    output logic [XLEN-1:0]   wb_io_data
);
    localparam int NB     = XLEN / 8;
    localparam int IDX_W  = XLEN - 3;

    logic              is_io;
    logic              ram_store;
    logic              io_rd;
    logic              io_wr;
    logic [NB-1:0]     lane_be;
    logic [XLEN-1:0]   lane_wd;
    logic [XLEN-1:0]   io_rdata;
    wb_pipe_t          pipe_d, pipe_q;

    assign is_io     = ex_alu[XLEN-1];
    assign ram_store = ex_store_en & ~is_io;
    assign io_rd     = ex_is_load  &  is_io;
    assign io_wr     = ex_store_en &  is_io;

    store_lane_align #(.DW(XLEN)) u_align (
        .size_code (ex_iw[13:12]),
        .byte_off  (ex_alu[1:0]),
        .data_in   (ex_store_data),
        .lane_en   (lane_be),
        .data_out  (lane_wd)
    );

    io_space #(
        .DW    (XLEN),
        .AW    (IDX_W),
        .LED_W (LED_W),
        .BTN_W (BTN_W)
    ) u_io (
        .clk      (clk),
        .rst      (rst),
        .word_idx (ex_alu[XLEN-2:2]),
        .rd       (io_rd),
        .wr       (io_wr),
        .wdata    (ex_store_data[LED_W-1:0]),
        .btn      (btn_in),
        .rdata    (io_rdata),
        .led      (led_out)
    );

    // memory side and forwarding
    always_comb begin
        mem_we    = ram_store;
        mem_be    = ram_store ? lane_be : '0;
        mem_addr  = ex_alu[XLEN-1:2];
        mem_wdata = lane_wd;
        fwd_en    = ex_wb_en & ~(ex_is_load & ~is_io);
        fwd_reg   = ex_wb_reg;
        fwd_data  = io_rd ? io_rdata : ex_alu;
    end

    // writeback pipeline next state
    always_comb begin
        pipe_d.en      = ex_wb_en;
        pipe_d.rd      = ex_wb_reg;
        pipe_d.pc      = ex_pc;
        pipe_d.iw      = ex_iw;
        pipe_d.alu     = ex_alu;
        pipe_d.io_data = io_rdata;
        if (io_rd)           pipe_d.src = SRC_IO;
        else if (ex_is_load) pipe_d.src = SRC_MEM;
        else                 pipe_d.src = SRC_ALU;
    end

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= pipe_d;
    end

    assign wb_en      = pipe_q.en;
    assign wb_reg     = pipe_q.rd;
    assign wb_pc      = pipe_q.pc;
    assign wb_iw      = pipe_q.iw;
    assign wb_alu     = pipe_q.alu;
    assign wb_src_sel = pipe_q.src;
    assign wb_io_data = pipe_q.io_data;
endmodule

// File: rtl/mem_stage_router_chk.sv
module mem_stage_router_chk #(
    parameter int LED_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             ex_wb_en,
    input logic [31:0]      ex_alu,
    input logic [31:0]      ex_store_data,
    input logic             ex_store_en,
    input logic             ex_is_load,
    input logic             mem_we,
    input logic             btn_in,
    input logic [LED_W-1:0] led_out,
    input logic             fwd_en,
    input logic [31:0]      fwd_data,
    input logic             wb_en,
    input logic [1:0]       wb_src_sel
);
    assert_io_no_ram_write_R1: assert property (@(posedge clk) disable iff (rst)
        (ex_store_en && ex_alu[31]) |-> !mem_we);

    assert_ram_store_write_R1: assert property (@(posedge clk) disable iff (rst)
        (ex_store_en && !ex_alu[31]) |-> mem_we);

    assert_io_load_src_R4: assert property (@(posedge clk) disable iff (rst)
        (ex_is_load && ex_alu[31]) |=> (wb_src_sel == 2'b10));

    assert_btn_read_R5: assert property (@(posedge clk) disable iff (rst)
        (ex_is_load && ex_alu == 32'h8000_0000) |-> (fwd_data == {31'b0, btn_in}));

    assert_led_write_R6: assert property (@(posedge clk) disable iff (rst)
        (ex_store_en && ex_alu[31:2] == 30'h2000_0001) |=> (led_out == $past(ex_store_data[LED_W-1:0])));

    assert_led_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!rst && !(ex_store_en && ex_alu[31:2] == 30'h2000_0001)) |=> $stable(led_out));

    assert_ram_load_no_fwd_R9: assert property (@(posedge clk) disable iff (rst)
        (ex_is_load && !ex_alu[31]) |-> !fwd_en);

    assert_fwd_follows_R9: assert property (@(posedge clk) disable iff (rst)
        (!ex_is_load) |-> (fwd_en == ex_wb_en));

    assert_reset_clears_R10: assert property (@(posedge clk)
        rst |=> (!wb_en && wb_src_sel == 2'b00 && led_out == '0));
endmodule

bind mem_stage_router mem_stage_router_chk #(.LED_W(LED_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .ex_wb_en      (ex_wb_en),
    .ex_alu        (ex_alu),
    .ex_store_data (ex_store_data),
    .ex_store_en   (ex_store_en),
    .ex_is_load    (ex_is_load),
    .mem_we        (mem_we),
    .btn_in        (btn_in[0]),
    .led_out       (led_out),
    .fwd_en        (fwd_en),
    .fwd_data      (fwd_data),
    .wb_en         (wb_en),
    .wb_src_sel    (wb_src_sel)
);

// File: tb/mem_stage_router_bench.sv
`timescale 1ns/1ps
module mem_stage_router_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ex_wb_en = 0;
    logic [4:0]  ex_wb_reg = 0;
    logic [31:0] ex_pc = 0, ex_iw = 0, ex_alu = 0, ex_store_data = 0;
    logic        ex_store_en = 0, ex_is_load = 0;
    logic        mem_we;
    logic [3:0]  mem_be;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [0:0]  btn_in = 0;
    logic [9:0]  led_out;
    logic        fwd_en;
    logic [4:0]  fwd_reg;
    logic [31:0] fwd_data;
    logic        wb_en;
    logic [4:0]  wb_reg;
    logic [31:0] wb_pc, wb_iw, wb_alu, wb_io_data;
    logic [1:0]  wb_src_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [9:0] led_model = '0;

    always #5 clk = ~clk;

    mem_stage_router u_mem_stage_router (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [1:0] off);
        logic [3:0] r = '0;
        for (int b = 0; b < 4; b++) begin
            if (sz == 2'b00)      r[b] = (b == off);
            else if (sz == 2'b01) r[b] = ((b / 2) == off[1]);
            else                  r[b] = 1'b1;
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_wd(input logic [1:0] sz, input logic [1:0] off, input logic [31:0] d);
        logic [31:0] r = '0;
        logic [3:0] be = exp_be(sz, off);
        int start = (sz == 2'b00) ? off : (sz == 2'b01) ? 2 * off[1] : 0;
        for (int b = 0; b < 4; b++)
            if (be[b]) r[8*b +: 8] = d[8*(b-start) +: 8];
        return r;
    endfunction

    function automatic logic [31:0] exp_io(input logic [31:0] a, input logic ld, input logic btn);
        if (ld && a[31] && a[30:2] == 29'd0) return {31'b0, btn};
        return 32'h0;
    endfunction

    // one access: drive after negedge, check comb now, registered at next negedge
    task automatic access(input logic [31:0] a, input logic st, input logic ld,
                          input logic [1:0] sz, input logic [31:0] sd, input logic btn);
        logic [31:0] iw = $urandom;
        logic [4:0]  rd = 5'($urandom);
        logic [31:0] pc = $urandom;
        logic        we = 1'($urandom);
        logic        io = a[31];
        logic [31:0] iov;
        iw[13:12] = sz;
        ex_alu = a; ex_store_en = st; ex_is_load = ld; ex_iw = iw;
        ex_store_data = sd; ex_wb_reg = rd; ex_pc = pc; ex_wb_en = we; btn_in = btn;
        iov = exp_io(a, ld, btn);
        #1;
        chk("R1 mem_we", {31'b0, mem_we}, {31'b0, st && !io});
        chk("R2 mem_addr", {2'b0, mem_addr}, {2'b0, a[31:2]});
        chk("R3 mem_be", {28'b0, mem_be}, (st && !io) ? {28'b0, exp_be(sz, a[1:0])} : 32'h0);
        if (st && !io) chk("R3 mem_wdata", mem_wdata, exp_wd(sz, a[1:0], sd));
        chk("R9 fwd_en", {31'b0, fwd_en}, {31'b0, we && !(ld && !io)});
        chk("R9 fwd_reg", {27'b0, fwd_reg}, {27'b0, rd});
        chk("R9 R5 fwd_data", fwd_data, (ld && io) ? iov : a);
        if (st && io && a[30:2] == 29'd1) led_model = sd[9:0];
        @(negedge clk);
        chk("R11 wb_en", {31'b0, wb_en}, {31'b0, we});
        chk("R11 wb_reg", {27'b0, wb_reg}, {27'b0, rd});
        chk("R11 wb_pc", wb_pc, pc);
        chk("R11 wb_iw", wb_iw, iw);
        chk("R11 wb_alu", wb_alu, a);
        chk("R4 wb_src_sel", {30'b0, wb_src_sel}, (ld && io) ? 32'd2 : ld ? 32'd1 : 32'd0);
        chk("R5 R7 R8 wb_io_data", wb_io_data, iov);
        chk("R6 R7 R8 led_out", {22'b0, led_out}, {22'b0, led_model});
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (2) @(negedge clk);
        chk("R10 wb_en", {31'b0, wb_en}, 0);
        chk("R10 wb_src_sel", {30'b0, wb_src_sel}, 0);
        chk("R10 led_out", {22'b0, led_out}, 0);
        chk("R10 wb_alu", wb_alu, 0);
        rst = 1'b0;

        // directed corner cases
        access(32'h8000_0000, 0, 1, 2'b10, 0, 1'b1);             // R5 button read high
        access(32'h8000_0000, 0, 1, 2'b10, 0, 1'b0);             // R5 button read low
        access(32'h8000_0004, 1, 0, 2'b10, 32'hFFFF_F2A5, 0);    // R6 led write
        access(32'h8000_0000, 1, 0, 2'b10, 32'h0000_0111, 1);    // R7 write to button ignored
        access(32'h8000_0004, 0, 1, 2'b10, 0, 1);                // R7 led reads zero
        access(32'h8000_0040, 1, 0, 2'b10, 32'h0000_0055, 1);    // R8 unmapped write ignored
        access(32'h8000_0040, 0, 1, 2'b10, 0, 1);                // R8 unmapped read zero
        access(32'h0000_0103, 1, 0, 2'b00, 32'h1234_56AB, 0);    // R3 byte lane 3
        access(32'h0000_0102, 1, 0, 2'b01, 32'h1234_CDEF, 0);    // R3 upper halfword
        access(32'h0000_0100, 1, 0, 2'b10, 32'hDEAD_BEEF, 0);    // R3 word
        access(32'h0000_0200, 0, 1, 2'b10, 0, 1);                // R4 R9 RAM load

        // constrained random
        for (int i = 0; i < 600; i++) begin
            logic [31:0] a;
            int kind = $urandom_range(0, 4);
            int op   = $urandom_range(0, 2);
            case (kind)
                0, 1: a = {1'b0, 31'($urandom)};
                2:    a = 32'h8000_0000;
                3:    a = 32'h8000_0004;
                default: a = {1'b1, 31'($urandom)};
            endcase
            access(a, op == 1, op == 2, 2'($urandom_range(0, 3)), $urandom, 1'($urandom));
        end

        // reset mid-run
        ex_store_en = 1; ex_alu = 32'h8000_0004; ex_store_data = 32'h3FF; ex_wb_en = 1;
        rst = 1'b1;
        @(negedge clk);
        chk("R10 led_out after reset", {22'b0, led_out}, 0);
        chk("R10 wb_en after reset", {31'b0, wb_en}, 0);
        chk("R10 wb_pc after reset", wb_pc, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(1_500_000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule